// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block stands in front of a bank of configuration registers and decides, write by write, whether a bus write may reach its target. A group of protected offsets covers the control, initialisation/status, prescaler, time, date and alarm registers. Writes to these offsets are only passed on while the lock is open. Writes to any other offset pass untouched.

Software opens the lock by writing a fixed pair of byte values, one after the other, to a dedicated key offset. Any other value written there closes the lock again. The key offset holds no storage of its own, so no write to it is ever forwarded. The downstream register bank therefore always returns zero for that offset.

The block is a small three-state sequencer driven by key writes, plus an address decoder and a combinational grant gate. The surrounding register file uses `wr_grant` as its write enable in place of the raw strobe.

Top module: `wrlock_guard`

## Requirements
- R1: After reset the lock is closed: a write to any protected offset (0x00, 0x04, 0x08, 0x0C, 0x10, 0x1C) gives `wr_grant` = 0.
- R2: A key write (offset 0x24) of byte 0xCA followed by a key write of 0x53 opens the lock. From the cycle after the 0x53 write, protected writes give `wr_grant` = 1.
- R3: A key write of any byte other than the one expected next (for example 0xFF) closes the lock. This holds in every state. While the lock is open, 0xCA also closes it, and that 0xCA counts as the first key of a new sequence.
- R4: Once open, the lock stays open across any number of protected and unprotected writes until a closing key write arrives.
- R5: A key write of 0x53 that does not directly follow a key write of 0xCA leaves the lock closed.
- R6: A key write of 0xCA while waiting for the second key keeps the sequence waiting for 0x53, so 0xCA, 0xCA, 0x53 opens the lock.
- R7: A write to any offset that is neither protected nor the key offset gives `wr_grant` = 1 whatever the lock state.
- R8: A write to the key offset never gives `wr_grant` = 1.
- R9: Cycles with `wr_en` = 0 give `wr_grant` = 0 and do not advance the key sequence. Writes to non-key offsets between the two key writes do not break the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_key_byte | input | 8 | Low data byte of the write, compared against the keys |
| wr_grant | output | 1 | Qualified write enable for the register bank |

## Verification
`wr_grant` is combinational. It is due in the same cycle as the write it qualifies, and it reflects the lock state registered at the previous edge. A change of lock state caused by a key write becomes visible only from the next cycle. The bench drives each write just after a falling edge and samples `wr_grant` two nanoseconds later, before the rising edge. It advances its own reference state at that rising edge. As a result, every key write is judged against the state that held before it, and every following write against the updated state.

// File: rtl/wrlock_pkg.sv
package wrlock_pkg;

    localparam int KEY_W = 8;

    localparam logic [KEY_W-1:0] KEY_OPEN_A = 8'hCA;
    localparam logic [KEY_W-1:0] KEY_OPEN_B = 8'h53;

    typedef enum logic [1:0] {
        LK_SHUT  = 2'd0,
        LK_ARMED = 2'd1,
        LK_OPEN  = 2'd2
    } lk_state_e;

    typedef struct packed {
        lk_state_e state;
    } lk_regs_t;

endpackage

// File: rtl/wrlock_addr_dec.sv
module wrlock_addr_dec #(
    parameter int ADDR_W   = 8,
    parameter int NUM_PROT = 6,
    parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST = '0,
    parameter logic [ADDR_W-1:0] KEY_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_key,
    output logic              hit_prot
);

    logic [NUM_PROT-1:0] match;

    for (genvar g = 0; g < NUM_PROT; g++) begin : g_cmp
        assign match[g] = (addr == PROT_LIST[g*ADDR_W +: ADDR_W]);
    end

    assign hit_prot = |match;
    assign hit_key  = (addr == KEY_ADDR);

endmodule

// File: rtl/wrlock_key_fsm.sv
module wrlock_key_fsm
    import wrlock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_byte,
    output logic             unlocked
);

    lk_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (key_wr) begin
            unique case (regs_q.state)
                LK_SHUT: begin
                    regs_d.state = (key_byte == KEY_OPEN_A) ? LK_ARMED : LK_SHUT;
                end
                LK_ARMED: begin
                    if (key_byte == KEY_OPEN_B)      regs_d.state = LK_OPEN;
                    else if (key_byte == KEY_OPEN_A) regs_d.state = LK_ARMED;
                    else                             regs_d.state = LK_SHUT;
                end
                LK_OPEN: begin
                    regs_d.state = (key_byte == KEY_OPEN_A) ? LK_ARMED : LK_SHUT;
                end
                default: regs_d.state = LK_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: LK_SHUT};
        else        regs_q <= regs_d;
    end

    assign unlocked = (regs_q.state == LK_OPEN);

    // R2: the lock only opens on the cycle after a second-key write
    assert_open_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(key_wr && key_byte == KEY_OPEN_B));

    // R3: an unexpected key byte always lands in the closed state
    assert_wrong_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_byte != KEY_OPEN_A && key_byte != KEY_OPEN_B)
        |=> (regs_q.state == LK_SHUT));

    // R4: without a key write the open state is held
    assert_hold_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && !key_wr) |=> unlocked);

    // R5: a second key from the closed state does not open
    assert_lone_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && regs_q.state == LK_SHUT) |=> !unlocked);

    // R6: first key while armed stays armed
    assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_byte == KEY_OPEN_A) |=> (regs_q.state == LK_ARMED));

endmodule

// File: rtl/wrlock_gate.sv
module wrlock_gate (
    input  logic wr_en,
    input  logic hit_key,
    input  logic hit_prot,
    input  logic unlocked,
    output logic grant
);

    always_comb begin
        grant = 1'b0;
        if (wr_en && !hit_key) begin
            grant = hit_prot ? unlocked : 1'b1;
        end
    end

endmodule

// File: rtl/wrlock_guard.sv
module wrlock_guard
    import wrlock_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_PROT = 6,
    parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST =
        {8'h1C, 8'h10, 8'h0C, 8'h08, 8'h04, 8'h00},
    parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_key_byte,
    output logic              wr_grant
);

    logic hit_key, hit_prot, unlocked, key_wr;

    wrlock_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_PROT (NUM_PROT),
        .PROT_LIST(PROT_LIST),
        .KEY_ADDR (KEY_ADDR)
    ) u_dec (
        .addr    (wr_addr),
        .hit_key (hit_key),
        .hit_prot(hit_prot)
    );

    assign key_wr = wr_en && hit_key;

    wrlock_key_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_byte(wr_key_byte),
        .unlocked(unlocked)
    );

    wrlock_gate u_gate (
        .wr_en   (wr_en),
        .hit_key (hit_key),
        .hit_prot(hit_prot),
        .unlocked(unlocked),
        .grant   (wr_grant)
    );

    // R9: no grant without a strobe
    assert_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |-> wr_en);

    // R8: the key offset is never forwarded
    assert_key_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == KEY_ADDR) |-> !wr_grant);

    // R1: a protected write granted implies the lock is open
    assert_prot_needs_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_grant && hit_prot) |-> unlocked);

endmodule

// File: tb/wrlock_guard_tb.sv
module wrlock_guard_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_key_byte = 8'h00;
    logic       wr_grant;

    int n_chk = 0;
    int n_bad = 0;
    int mstate = 0; // 0 closed, 1 waiting for second key, 2 open

    always #4 clk = ~clk;

    wrlock_guard u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_key_byte(wr_key_byte),
        .wr_grant   (wr_grant)
    );

    function automatic bit is_prot(input logic [7:0] a);
        return (a == 8'h00 || a == 8'h04 || a == 8'h08 ||
                a == 8'h0C || a == 8'h10 || a == 8'h1C);
    endfunction

    function automatic logic exp_grant(input int st, input logic en, input logic [7:0] a);
        if (!en || a == 8'h24) return 1'b0;
        if (is_prot(a)) return (st == 2);
        return 1'b1;
    endfunction

    function automatic int exp_next(input int st, input logic en,
                                    input logic [7:0] a, input logic [7:0] d);
        if (!en || a != 8'h24) return st;
        if (st == 1 && d == 8'h53) return 2;
        if (d == 8'hCA) return 1;
        return 0;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic drive(input logic en, input logic [7:0] a, input logic [7:0] d,
                         input string tag);
        logic e;
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_key_byte = d;
        #2;
        e = exp_grant(mstate, en, a);
        n_chk++;
        if (wr_grant !== e) begin
            n_bad++;
            $display("FAIL %s: wr_grant=%0b expected %0b (en %0b addr %02h byte %02h)",
                     tag, wr_grant, e, en, a, d);
        end
        @(posedge clk);
        mstate = exp_next(mstate, en, a, d);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: closed after reset
        drive(1, 8'h08, 8'h00, "R1");
        drive(1, 8'h1C, 8'h00, "R1");
        // R7: unprotected writes pass while closed
        drive(1, 8'h14, 8'h11, "R7");
        drive(1, 8'h40, 8'h22, "R7");
        // R2: open sequence
        drive(1, 8'h24, 8'hCA, "R8");
        drive(1, 8'h24, 8'h53, "R8");
        drive(1, 8'h00, 8'h01, "R2");
        // R4: persists
        drive(1, 8'h04, 8'h02, "R4");
        drive(1, 8'h30, 8'h03, "R4");
        drive(0, 8'h24, 8'hFF, "R9");
        drive(1, 8'h10, 8'h04, "R4");
        // R3: wrong key closes
        drive(1, 8'h24, 8'hFF, "R8");
        drive(1, 8'h0C, 8'h00, "R3");
        // R3: 0xCA while open closes
        drive(1, 8'h24, 8'hCA, "R3");
        drive(1, 8'h24, 8'h53, "R3");
        drive(1, 8'h24, 8'hCA, "R3");
        drive(1, 8'h08, 8'h00, "R3");
        drive(1, 8'h24, 8'h00, "R3");
        // R5: lone second key
        drive(1, 8'h24, 8'h53, "R5");
        drive(1, 8'h00, 8'h00, "R5");
        // R6: re-arm
        drive(1, 8'h24, 8'hCA, "R6");
        drive(1, 8'h24, 8'hCA, "R6");
        drive(1, 8'h24, 8'h53, "R6");
        drive(1, 8'h1C, 8'h00, "R6");
        drive(1, 8'h24, 8'hFF, "R6");
        // R9: strobe low does not advance, intervening writes do not break
        drive(0, 8'h24, 8'hCA, "R9");
        drive(0, 8'h24, 8'h53, "R9");
        drive(1, 8'h04, 8'h00, "R9");
        drive(1, 8'h24, 8'hCA, "R9");
        drive(1, 8'h18, 8'h00, "R9");
        drive(1, 8'h08, 8'h00, "R9");
        drive(1, 8'h24, 8'h53, "R9");
        drive(1, 8'h08, 8'h00, "R9");
        drive(0, 8'h08, 8'h00, "R9");

        // mixed random traffic
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a, d;
            int ra, rd;
            ra = $urandom_range(0, 5);
            rd = $urandom_range(0, 4);
            case (ra)
                0, 1: a = 8'h24;
                2: begin
                    case ($urandom_range(0, 5))
                        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08;
                        3: a = 8'h0C; 4: a = 8'h10; default: a = 8'h1C;
                    endcase
                end
                3: a = 8'h04;
                default: a = 8'($urandom_range(0, 255));
            endcase
            case (rd)
                0, 1: d = 8'hCA;
                2: d = 8'h53;
                3: d = 8'hFF;
                default: d = 8'($urandom_range(0, 255));
            endcase
            drive(($urandom_range(0, 7) != 0), a, d, "RND");
        end

        summary();
        $finish;
    end

endmodule